// File: doc/BRIEF.md
# Three-Encoding Six-Bit Adder

This block adds two operand words and reports a sum word together with an overflow flag. A two-bit mode input states how the operand bits are to be read: as plain unsigned integers, as two's-complement integers, or as biased integers in which a value x is held as the code x + 31. One binary adder serves all three readings. The unsigned and two's-complement readings take its result as it is and judge overflow by different rules. The biased reading first removes the surplus bias from the raw sum and then judges overflow on the corrected value.

The word width is a parameter with a default of 6, and the bias is derived from it as 2^(W-1) - 1. By default the sum and flag pass through one output register, so a result appears one clock after its operands. That register is cleared by an active-low asynchronous reset. A parameter removes the register and makes the block purely combinational.

Top module: `tri_code_adder`

## Requirements
- R1: When mode_i is 2'b00, 2'b01 or 2'b11, sum_o is (a_i + b_i) mod 64, the same for all three codes.
- R2: When mode_i is 2'b00 (unsigned), ovf_o is 1 exactly when a_i + b_i exceeds 63, which is a carry out of bit 5.
- R3: When mode_i is 2'b01 (two's complement, bit 5 is the sign), the carry out is ignored. ovf_o is 1 exactly when both operands have the same sign and the sign of sum_o differs from it. This is equivalent to the signed sum lying outside -32..31.
- R4: When mode_i is 2'b10 (excess-31), sum_o is (a_i + b_i - 31) mod 64, which is the correctly biased code of the true sum.
- R5: When mode_i is 2'b10, ovf_o is 1 exactly when a_i + b_i - 31 is below 0 or above 63.
- R6: mode_i 2'b11 gives the same sum_o and ovf_o as mode_i 2'b00.
- R7: With the output register present, sum_o and ovf_o show the result for the operands and mode sampled at the previous rising clock edge. While rst_ni is low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_i | input | WIDTH | First operand code |
| b_i | input | WIDTH | Second operand code |
| mode_i | input | 2 | Encoding select: 00 unsigned, 01 two's complement, 10 excess-31, 11 as unsigned |
| sum_o | output | WIDTH | Result code |
| ovf_o | output | 1 | Overflow flag for the selected encoding |

## Verification
The checker assumes that a_i, b_i and mode_i carry known values at every rising edge once reset is released. It also assumes that the output it inspects was produced from the inputs that it captured itself one edge earlier. For that reason its arithmetic checks stay idle until one edge after reset. The bench changes inputs only on falling edges. It holds each operand pair for a full cycle, and it drives all four mode codes, including the spare one, so that every check sees defined data.

// File: rtl/tri_adder_pkg.sv
package tri_adder_pkg;
  typedef enum logic [1:0] {
    MODE_UNS = 2'b00,
    MODE_TWC = 2'b01,
    MODE_EXC = 2'b10,
    MODE_SPR = 2'b11
  } add_mode_e;
endpackage

// File: rtl/tri_add_core.sv
// shared binary adder, carry kept as top bit
module tri_add_core #(
  parameter int WIDTH = 6
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH:0]   raw_o
);
  assign raw_o = {1'b0, a_i} + {1'b0, b_i};
endmodule

// File: rtl/tri_add_judge.sv
module tri_add_judge import tri_adder_pkg::*; #(
  parameter int WIDTH = 6
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       mode_i,
  input  logic [WIDTH:0]   raw_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             ovf_o
);
  localparam int BIAS = (1 << (WIDTH - 1)) - 1;
  localparam int XW   = WIDTH + 2;

  logic [XW-1:0] exc_val;
  logic          ovf_uns, ovf_twc, ovf_exc;

  // signed intermediate: raw - bias, two guard bits
  assign exc_val = {1'b0, raw_i} - XW'(BIAS);
  assign ovf_exc = |exc_val[XW-1:WIDTH];
  assign ovf_uns = raw_i[WIDTH];
  assign ovf_twc = (a_i[WIDTH-1] == b_i[WIDTH-1]) && (raw_i[WIDTH-1] != a_i[WIDTH-1]);

  always_comb begin
    sum_o = raw_i[WIDTH-1:0];
    ovf_o = ovf_uns;
    case (add_mode_e'(mode_i))
      MODE_TWC: ovf_o = ovf_twc;
      MODE_EXC: begin
        sum_o = exc_val[WIDTH-1:0];
        ovf_o = ovf_exc;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tri_add_stage.sv
module tri_add_stage #(
  parameter int WIDTH   = 6,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sum_i,
  input  logic             ovf_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             ovf_o
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sum_o <= '0;
        ovf_o <= 1'b0;
      end else begin
        sum_o <= sum_i;
        ovf_o <= ovf_i;
      end
    end
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign sum_o = sum_i;
    assign ovf_o = ovf_i;
  end
endmodule

// File: rtl/tri_code_adder.sv
module tri_code_adder #(
  parameter int WIDTH   = 6,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       mode_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             ovf_o
);
  logic [WIDTH:0]   raw;
  logic [WIDTH-1:0] sum_d;
  logic             ovf_d;

  tri_add_core #(.WIDTH(WIDTH)) u_core (
    .a_i(a_i), .b_i(b_i), .raw_o(raw)
  );

  tri_add_judge #(.WIDTH(WIDTH)) u_judge (
    .a_i(a_i), .b_i(b_i), .mode_i(mode_i), .raw_i(raw),
    .sum_o(sum_d), .ovf_o(ovf_d)
  );

  tri_add_stage #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_stage (
    .clk_i(clk_i), .rst_ni(rst_ni), .sum_i(sum_d), .ovf_i(ovf_d),
    .sum_o(sum_o), .ovf_o(ovf_o)
  );
endmodule

// File: rtl/tri_code_adder_chk.sv
module tri_code_adder_chk import tri_adder_pkg::*; #(
  parameter int WIDTH   = 6,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [1:0]       mode_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             ovf_o
);
  localparam int MAXV = (1 << WIDTH) - 1;
  localparam int BIAS = (1 << (WIDTH - 1)) - 1;
  localparam int SMAX = BIAS;
  localparam int SMIN = -(BIAS + 1);

  logic [WIDTH-1:0] ea, eb;
  logic [1:0]       em;
  logic             ok;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ea <= '0; eb <= '0; em <= '0; ok <= 1'b0;
      end else begin
        ea <= a_i; eb <= b_i; em <= mode_i; ok <= 1'b1;
      end
    end
    AST_RESET_CLEAR: assert property (@(posedge clk_i) !rst_ni |-> (sum_o == '0 && !ovf_o)); // R7
  end else begin : g_comb
    assign ea = a_i;
    assign eb = b_i;
    assign em = mode_i;
    assign ok = 1'b1;
  end

  int ua, ub, sa, sb;
  always_comb begin
    ua = int'(ea);
    ub = int'(eb);
    sa = ea[WIDTH-1] ? ua - (MAXV + 1) : ua;
    sb = eb[WIDTH-1] ? ub - (MAXV + 1) : ub;
  end

  AST_SHARED_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok && em != MODE_EXC |-> sum_o == WIDTH'(ua + ub)); // R1
  AST_UNS_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok && em == MODE_UNS |-> ovf_o == (ua + ub > MAXV)); // R2
  AST_TWC_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok && em == MODE_TWC |-> ovf_o == (sa + sb > SMAX || sa + sb < SMIN)); // R3
  AST_EXC_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok && em == MODE_EXC |-> sum_o == WIDTH'(ua + ub - BIAS)); // R4
  AST_EXC_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok && em == MODE_EXC |-> ovf_o == (ua + ub - BIAS < 0 || ua + ub - BIAS > MAXV)); // R5
  AST_SPARE_AS_UNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok && em == MODE_SPR |-> ovf_o == (ua + ub > MAXV)); // R6
endmodule

bind tri_code_adder tri_code_adder_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .mode_i(mode_i),
  .sum_o(sum_o), .ovf_o(ovf_o)
);

// File: tb/tri_code_adder_bench.sv
`timescale 1ns/1ps
module tri_code_adder_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] a_i = '0, b_i = '0;
  logic [1:0] mode_i = '0;
  logic [5:0] sum_o;
  logic       ovf_o;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  tri_code_adder u_tri_code_adder (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .mode_i(mode_i),
    .sum_o(sum_o), .ovf_o(ovf_o)
  );

  task automatic check(input string req, input int a, input int b, input int m,
                       input int exp_s, input bit exp_o);
    checks++;
    if (sum_o !== 6'(exp_s) || ovf_o !== exp_o) begin
      errors++;
      $display("FAIL %s mode=%0d a=%0d b=%0d: got sum=%0d ovf=%0d, expected sum=%0d ovf=%0d",
               req, m, a, b, sum_o, ovf_o, exp_s & 63, exp_o);
    end
  endtask

  task automatic apply_and_check(input int a, input int b, input int m, input string req);
    int es; bit eo; int sa, sb, v;
    a_i = 6'(a); b_i = 6'(b); mode_i = 2'(m);
    @(negedge clk_i);
    case (m)
      1: begin
        sa = a >= 32 ? a - 64 : a;
        sb = b >= 32 ? b - 64 : b;
        es = (a + b) % 64;
        eo = (sa + sb > 31) || (sa + sb < -32);
      end
      2: begin
        v = a + b - 31;
        es = (v + 128) % 64;
        eo = (v < 0) || (v > 63);
      end
      default: begin
        es = (a + b) % 64;
        eo = (a + b) > 63;
      end
    endcase
    check(req, a, b, m, es, eo);
  endtask

  initial begin
    #100000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    a_i = 6'd63; b_i = 6'd63; mode_i = 2'd2;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R7 reset", 63, 63, 2, 0, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // named corners
    apply_and_check(63, 1, 0, "R2 carry out");
    apply_and_check(31, 1, 1, "R3 pos+pos overflow");
    apply_and_check(32, 32, 1, "R3 neg+neg overflow, carry ignored");
    apply_and_check(63, 1, 1, "R3 carry without overflow");
    apply_and_check(31, 31, 2, "R4 zero plus zero");
    apply_and_check(0, 0, 2, "R5 underflow");
    apply_and_check(63, 63, 2, "R5 overflow");
    apply_and_check(63, 31, 2, "R5 top of range");
    apply_and_check(63, 1, 3, "R6 spare code");

    // exhaustive sweep, one cycle latency per pair
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 64; a++)
        for (int b = 0; b < 64; b++)
          apply_and_check(a, b, m,
            m == 0 ? "R1 R2 unsigned" : m == 1 ? "R1 R3 twos" :
            m == 2 ? "R4 R5 excess" : "R6 spare");

    // latency: output follows previous edge, then holds
    apply_and_check(10, 20, 0, "R7 latency");
    rst_ni = 1'b0;
    #1;
    check("R7 async clear", 10, 20, 0, 0, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule